// File: doc/BRIEF.md
# Diagnosed Low-Side Output Controller

This block is the digital control for a set of identical open-drain low-side output stages, two by default. Each channel has its own request input and drives the enable of its output transistor. The request is active low, so the output pin follows it without inversion: a low request switches the transistor on and pulls the pin low. An unconnected request input is held high by its pull-up, and the stage then stays off. The analog side of each stage reports the pin voltage as three comparator flags. Those flags are the only view the controller has of the pin.

Each flag is judged only in the output state where it means something. A pin that stays high while the stage is on is a short to battery. This is judged only after a blanking delay, which restarts at every switch-on. A pin held near ground while the stage is off is a short to ground. An open-load window reading while the stage is off is an open load. Every fault must persist across a parameterised number of consecutive sample ticks before it is latched. A confirmed short to battery switches the stage off and keeps it off until the channel's status is read and cleared. Software can disable open-load diagnosis per channel. This removes both the diagnostic current and the open-load report.

Top module: `lsout_diag`

## Requirements
- R1: `gate_en[i]` equals the inverse of `req_n[i]` sampled at the previous rising clock edge, unless the channel is locked off. A request held high, which includes an open input, keeps the gate at 0.
- R2: While `rst_n` is low, every `gate_en` bit is 0 at once, whatever the requests are, and all fault flags read 0.
- R3: A short to battery is evaluated only while the gate is on, and only once `BLANK` clock cycles have passed since the latest off-to-on transition. A high `cmp_hi` during the blanking window leaves `flt_scb` at 0.
- R4: A confirmed short to battery sets `flt_scb[i]` and forces `gate_en[i]` to 0 on the following clock edge.
- R5: After a short-to-battery shutdown, the gate stays at 0 while `req_n` toggles, until `stat_clr[i]` is pulsed.
- R6: A one-cycle `stat_clr[i]` pulse clears all three fault flags and the shutdown lock of channel i only. The gate follows the request again from the next edge.
- R7: A fault is latched on the `FILT_LEN`-th consecutive `tick` pulse during which its condition holds. If the condition drops for any single clock cycle, the count restarts.
- R8: A short to ground (`cmp_gnd` high) is evaluated only while the gate is off. With the gate on, `flt_scg` stays 0.
- R9: An open load (`cmp_ol` high) is evaluated only while the gate is off and `ol_dis[i]` is 0. Otherwise `flt_ol` stays 0.
- R10: `diag_cur_en[i]` is 1 exactly when the gate of channel i is off and `ol_dis[i]` is 0.
- R11: A fault on one channel changes no flag and no gate of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low; forces all gates off |
| tick | input | 1 | Fault-filter sample strobe, one cycle wide |
| req_n | input | NCH | Per-channel request, low = stage on |
| ol_dis | input | NCH | Per-channel open-load diagnosis disable |
| cmp_hi | input | NCH | Pin above the short-to-battery threshold |
| cmp_gnd | input | NCH | Pin below the short-to-ground threshold |
| cmp_ol | input | NCH | Pin inside the open-load window |
| stat_clr | input | NCH | Per-channel status read-and-clear strobe |
| gate_en | output | NCH | Output transistor enable |
| diag_cur_en | output | NCH | Open-load diagnostic current source enable |
| flt_scb | output | NCH | Latched short to battery |
| flt_scg | output | NCH | Latched short to ground |
| flt_ol | output | NCH | Latched open load |

## Verification
The assertions take the request, comparator and clear inputs to be synchronous to `clk`. They also take `tick` to be a pulse of at most one cycle. With that, every change of a fault flag can be traced to the gate state and the comparator flag one edge earlier. The bench changes all inputs on the falling edge and keeps `tick` high for exactly one rising edge per pulse. It holds the comparator flags steady across each run of ticks, except where a drop is the point of the test. It also counts the blanking window in whole clock cycles from the edge at which the gate came on.

// File: rtl/lsout_pkg.sv
package lsout_pkg;
    localparam int NFLT   = 3;
    localparam int FK_SCB = 0;
    localparam int FK_SCG = 1;
    localparam int FK_OL  = 2;
endpackage

// File: rtl/lsout_filt.sv
module lsout_filt #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic raw,
    output logic hit
);
    localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
    localparam logic [CW-1:0] LIM = CW'(FILT_LEN - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        hit   = raw & tick & (cnt_q == LIM);
        if (!raw) begin
            cnt_d = '0;
        end else if (tick && cnt_q != LIM) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    generate
        if (FILT_LEN > 1) begin : g_hold_chk
            assert_filt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
                hit |-> $past(raw));
        end
    endgenerate
endmodule

// File: rtl/lsout_chan.sv
module lsout_chan
    import lsout_pkg::*;
#(
    parameter int BLANK    = 8,
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic req_n,
    input  logic ol_dis,
    input  logic cmp_hi,
    input  logic cmp_gnd,
    input  logic cmp_ol,
    input  logic clr,
    output logic gate,
    output logic diag_cur,
    output logic flt_scb,
    output logic flt_scg,
    output logic flt_ol
);
    localparam int BW = (BLANK > 0) ? $clog2(BLANK + 1) : 1;
    localparam logic [BW-1:0] BLANK_LD = BW'(BLANK);

    typedef struct packed {
        logic            gate;
        logic            lock;
        logic [BW-1:0]   blank;
        logic [NFLT-1:0] flt;
    } st_t;

    st_t st_d, st_q;
    logic [NFLT-1:0] raw, hit;
    logic blank_done;

    generate
        for (genvar k = 0; k < NFLT; k++) begin : g_filt
            lsout_filt #(.FILT_LEN(FILT_LEN)) u_filt (
                .clk   (clk),
                .rst_n (rst_n),
                .tick  (tick),
                .raw   (raw[k]),
                .hit   (hit[k])
            );
        end
    endgenerate

    always_comb begin
        blank_done  = (st_q.blank == '0);
        raw         = '0;
        raw[FK_SCB] = st_q.gate & blank_done & cmp_hi;
        raw[FK_SCG] = ~st_q.gate & cmp_gnd;
        raw[FK_OL]  = ~st_q.gate & ~ol_dis & cmp_ol;

        st_d      = st_q;
        st_d.flt  = (st_q.flt & {NFLT{~clr}}) | hit;
        st_d.lock = (st_q.lock & ~clr) | hit[FK_SCB];
        st_d.gate = ~req_n & ~st_q.lock & ~hit[FK_SCB];
        if (st_d.gate && !st_q.gate) begin
            st_d.blank = BLANK_LD;
        end else if (st_q.gate && !blank_done) begin
            st_d.blank = st_q.blank - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gate     = st_q.gate;
    assign diag_cur = ~st_q.gate & ~ol_dis;
    assign flt_scb  = st_q.flt[FK_SCB];
    assign flt_scg  = st_q.flt[FK_SCG];
    assign flt_ol   = st_q.flt[FK_OL];

    assert_gate_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.gate) |-> $past(!req_n));
    assert_scb_blank_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flt[FK_SCB]) |-> $past(st_q.gate && blank_done));
    assert_lock_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |-> !st_q.gate);
    assert_scg_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flt[FK_SCG]) |-> $past(!st_q.gate));
    assert_ol_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flt[FK_OL]) |-> $past(!st_q.gate && !ol_dis));
endmodule

// File: rtl/lsout_diag.sv
module lsout_diag #(
    parameter int NCH      = 2,
    parameter int BLANK    = 8,
    parameter int FILT_LEN = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic [NCH-1:0] req_n,
    input  logic [NCH-1:0] ol_dis,
    input  logic [NCH-1:0] cmp_hi,
    input  logic [NCH-1:0] cmp_gnd,
    input  logic [NCH-1:0] cmp_ol,
    input  logic [NCH-1:0] stat_clr,
    output logic [NCH-1:0] gate_en,
    output logic [NCH-1:0] diag_cur_en,
    output logic [NCH-1:0] flt_scb,
    output logic [NCH-1:0] flt_scg,
    output logic [NCH-1:0] flt_ol
);
    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            lsout_chan #(.BLANK(BLANK), .FILT_LEN(FILT_LEN)) u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .tick     (tick),
                .req_n    (req_n[i]),
                .ol_dis   (ol_dis[i]),
                .cmp_hi   (cmp_hi[i]),
                .cmp_gnd  (cmp_gnd[i]),
                .cmp_ol   (cmp_ol[i]),
                .clr      (stat_clr[i]),
                .gate     (gate_en[i]),
                .diag_cur (diag_cur_en[i]),
                .flt_scb  (flt_scb[i]),
                .flt_scg  (flt_scg[i]),
                .flt_ol   (flt_ol[i])
            );
        end
    endgenerate
endmodule

// File: tb/lsout_diag_tb.sv
module lsout_diag_tb;
    localparam int NCH = 2;
    localparam int BLANK = 8;
    localparam int FILT_LEN = 3;

    logic clk = 0;
    logic rst_n = 0;
    logic tick = 0;
    logic [NCH-1:0] req_n = '1, ol_dis = '0, cmp_hi = '0, cmp_gnd = '0, cmp_ol = '0, stat_clr = '0;
    logic [NCH-1:0] gate_en, diag_cur_en, flt_scb, flt_scg, flt_ol;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    lsout_diag #(.NCH(NCH), .BLANK(BLANK), .FILT_LEN(FILT_LEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .req_n(req_n), .ol_dis(ol_dis),
        .cmp_hi(cmp_hi), .cmp_gnd(cmp_gnd), .cmp_ol(cmp_ol), .stat_clr(stat_clr),
        .gate_en(gate_en), .diag_cur_en(diag_cur_en), .flt_scb(flt_scb),
        .flt_scg(flt_scg), .flt_ol(flt_ol)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick = 1;
            @(negedge clk); tick = 0;
        end
    endtask

    task automatic clear(input int ch);
        @(negedge clk); stat_clr[ch] = 1;
        @(negedge clk); stat_clr[ch] = 0;
    endtask

    task automatic t_reset_state;
        chk("R2 gate in reset", 32'(gate_en), 0);
        chk("R2 flags in reset", 32'({flt_scb, flt_scg, flt_ol}), 0);
        @(negedge clk); rst_n = 1;
        cyc(2);
        chk("R1 open input keeps off", 32'(gate_en), 0);
        chk("R10 diag current when off", 32'(diag_cur_en), 32'h3);
    endtask

    task automatic t_follow;
        @(negedge clk); req_n[0] = 0;
        @(negedge clk);
        chk("R1 gate on one edge later", 32'(gate_en), 32'h1);
        chk("R10 diag current off when on", 32'(diag_cur_en), 32'h2);
        req_n[0] = 1;
        @(negedge clk);
        chk("R1 gate off one edge later", 32'(gate_en), 0);
    endtask

    task automatic t_scb;
        cmp_hi[0] = 1;
        @(negedge clk); req_n[0] = 0;
        ticks(3);
        chk("R3 no SCB inside blanking", 32'(flt_scb), 0);
        chk("R3 gate still on in blanking", 32'(gate_en), 32'h1);
        cyc(4);
        ticks(2);
        chk("R7 SCB not yet after two ticks", 32'(flt_scb), 0);
        ticks(1);
        chk("R4 SCB latched", 32'(flt_scb), 32'h1);
        chk("R4 gate forced off", 32'(gate_en), 0);
        @(negedge clk); req_n[0] = 1;
        cyc(2); req_n[0] = 0;
        cyc(3);
        chk("R5 lock holds after toggle", 32'(gate_en), 0);
        chk("R5 SCB flag held", 32'(flt_scb), 32'h1);
        cmp_hi[0] = 0;
        clear(0);
        @(negedge clk);
        chk("R6 flag cleared", 32'(flt_scb), 0);
        chk("R6 gate follows after clear", 32'(gate_en), 32'h1);
        cmp_hi[0] = 1;
        ticks(3);
        chk("R3 blanking restarts on switch-on", 32'(flt_scb), 0);
        cyc(4);
        ticks(3);
        chk("R4 SCB relatched", 32'(flt_scb), 32'h1);
        cmp_hi[0] = 0; req_n[0] = 1;
        clear(0);
        cyc(1);
    endtask

    task automatic t_scg;
        @(negedge clk); cmp_gnd[0] = 1;
        ticks(2);
        cmp_gnd[0] = 0;
        @(negedge clk); cmp_gnd[0] = 1;
        ticks(2);
        chk("R7 drop restarts filter", 32'(flt_scg), 0);
        ticks(1);
        chk("R8 SCG latched when off", 32'(flt_scg), 32'h1);
        cmp_gnd[0] = 0;
        clear(0);
        @(negedge clk); req_n[0] = 0;
        cyc(2); cmp_gnd[0] = 1;
        ticks(4);
        chk("R8 SCG ignored when on", 32'(flt_scg), 0);
        cmp_gnd[0] = 0; req_n[0] = 1;
        cyc(2);
    endtask

    task automatic t_ol;
        @(negedge clk); ol_dis[0] = 1; cmp_ol[0] = 1;
        @(negedge clk);
        chk("R10 diag current zero when disabled", 32'(diag_cur_en[0]), 0);
        ticks(4);
        chk("R9 OL ignored when disabled", 32'(flt_ol), 0);
        ol_dis[0] = 0;
        @(negedge clk);
        chk("R10 diag current back on", 32'(diag_cur_en[0]), 32'h1);
        ticks(3);
        chk("R9 OL latched", 32'(flt_ol), 32'h1);
        clear(0);
        @(negedge clk); req_n[0] = 0;
        cyc(2);
        ticks(4);
        chk("R9 OL ignored when on", 32'(flt_ol), 0);
        cmp_ol[0] = 0; req_n[0] = 1;
        cyc(2);
    endtask

    task automatic t_indep;
        @(negedge clk); req_n[0] = 0; cmp_gnd[1] = 1;
        ticks(3);
        chk("R11 ch1 SCG latched", 32'(flt_scg), 32'h2);
        chk("R11 ch0 gate untouched", 32'(gate_en), 32'h1);
        clear(0);
        chk("R6 clear of ch0 keeps ch1 flag", 32'(flt_scg), 32'h2);
        cmp_gnd[1] = 0;
        clear(1);
        chk("R6 ch1 cleared", 32'(flt_scg), 0);
    endtask

    task automatic t_reset_live;
        @(negedge clk); req_n = '0; cmp_ol[1] = 1;
        cyc(2);
        req_n[1] = 1;
        ticks(3);
        chk("R9 ch1 OL before reset", 32'(flt_ol), 32'h2);
        #1 rst_n = 0;
        #0.5;
        chk("R2 reset drops gates at once", 32'(gate_en), 0);
        chk("R2 reset clears flags", 32'(flt_ol), 0);
    endtask

    initial begin
        #(4 * 50000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cyc(2);
        t_reset_state();
        t_follow();
        t_scb();
        t_scg();
        t_ol();
        t_indep();
        t_reset_live();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule